// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the front end of a flash memory's write path. Each bus write gives it an address and a 16-bit data word. The decoder reads the low byte of the data as a command code. It follows one-, two- and three-write command sequences. When a sequence completes, it sends a one-cycle start pulse to the program/erase engine, together with the operation kind and the latched address and data.

The decoder also chooses what a bus read returns: the array, the status register, the identifier/lock word, or query data. It takes two inputs from the engine, busy and suspended. From these it decides which codes are legal at each moment. While an operation runs, most codes are ignored. While an operation is suspended, only a limited set is honoured, and that set grows when the suspended operation is an erase.

The decoder keeps two error flags for the status register: erase failure and program failure. It also builds the identifier word that signature reads return.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, the decoder returns to read-array mode (rd_sel = 0) at that edge. Both error flags clear, no pulse is raised, and any partial sequence is dropped.
- R2: Writing 20h and then D0h raises op_start for one cycle, with op_kind 0 (erase) and op_addr equal to the address of the second write.
- R3: Writing 20h followed by any code other than D0h sets both err_erase (status bit 5) and err_prog (status bit 4). No operation starts, and reads then return status (rd_sel 1).
- R4: Writing 40h, or C0h, and then a second write starts the operation. The kind is 1 (word program) for 40h and 6 (protection-register program) for C0h. op_addr and op_data carry the second write.
- R5: Writing 30h and then two data writes starts kind 2 (double-word program), with the first word on op_addr/op_data and the second on op_addr2/op_data2. If the two addresses differ in any bit other than bit 0, err_prog is set, nothing starts, and the mode returns to read array.
- R6: Writing 60h and then 01h, D0h or 2Fh starts kind 3 (lock), 4 (unlock) or 5 (lock-down) at the second address. Any other second code starts nothing and returns to read array.
- R7: While the engine is busy and not suspended, rd_sel is 1 (status). Only 70h and B0h are acted on. Every other code is ignored, and the read mode it would have chosen does not take effect.
- R8: While the engine is suspended, FFh, 70h, 90h, 98h and D0h are honoured, and D0h raises resume_req for one cycle. The codes 40h, 60h and C0h start their sequences only if the suspended operation is an erase. In any other case they are ignored.
- R9: B0h raises suspend_req for one cycle while an erase or program runs. It is ignored while a protection-register program runs.
- R10: When idle, FFh selects array (rd_sel 0), 70h selects status (1), 90h selects signature (2) and 98h selects query (3). Any code that is not defined returns to array. 50h clears both error flags.
- R11: id_word reports by id_sel. A value of 0 gives 0020h and 1 gives the DEVICE_ID parameter. A value of 2 gives {14'b0, blk_lockdown, blk_locked}, and 3 gives 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 16 | Bus write data; low byte is the command code |
| eng_busy | input | 1 | Engine has an operation in progress |
| eng_susp | input | 1 | Engine operation is suspended |
| id_sel | input | 2 | Word select for signature reads |
| blk_locked | input | 1 | Lock bit of the addressed block |
| blk_lockdown | input | 1 | Lock-down bit of the addressed block |
| op_start | output | 1 | One-cycle operation start pulse |
| op_kind | output | 3 | Operation kind code |
| op_addr | output | ADDR_W | Latched (first) address |
| op_data | output | 16 | Latched (first) data |
| op_addr2 | output | ADDR_W | Second address of a double-word program |
| op_data2 | output | 16 | Second data of a double-word program |
| suspend_req | output | 1 | One-cycle suspend request |
| resume_req | output | 1 | One-cycle resume request |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 signature, 3 query |
| id_word | output | 16 | Identifier or lock-status word |
| err_erase | output | 1 | Status bit 5, erase failure |
| err_prog | output | 1 | Status bit 4, program failure |

## Verification
The hardest case to reach is the set of writes accepted during a suspension, because the result depends on which kind of operation was running when the suspend took effect. The bench acts as the engine. It starts an erase, raises busy, issues B0h, and then raises suspended before it tries the program and resume codes. It then repeats the same steps after a word-program start to show that 40h is refused. After the refused 40h, it writes 98h. If the decoder had wrongly entered the program sequence, it would start a program; the bench instead expects a plain query-mode switch.

// File: rtl/fcd_pkg.sv
// Shared types of the flash command decoder.
// Assumes: kind and mode encodings are visible to the engine and read path.
package fcd_pkg;
    typedef enum logic [2:0] {
        K_ERASE  = 3'd0,
        K_PROG   = 3'd1,
        K_DWPROG = 3'd2,
        K_LOCK   = 3'd3,
        K_UNLOCK = 3'd4,
        K_LOCKDN = 3'd5,
        K_PROT   = 3'd6
    } op_kind_e;

    typedef enum logic [1:0] {
        M_ARRAY  = 2'd0,
        M_STATUS = 2'd1,
        M_SIG    = 2'd2,
        M_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ERASE = 3'd1,
        S_PROG  = 3'd2,
        S_DW1   = 3'd3,
        S_DW2   = 3'd4,
        S_LOCK  = 3'd5,
        S_PROT  = 3'd6
    } seq_state_e;

    localparam logic [7:0] C_READ_ARRAY = 8'hFF;
    localparam logic [7:0] C_READ_STAT  = 8'h70;
    localparam logic [7:0] C_READ_SIG   = 8'h90;
    localparam logic [7:0] C_READ_QUERY = 8'h98;
    localparam logic [7:0] C_CLEAR      = 8'h50;
    localparam logic [7:0] C_SUSPEND    = 8'hB0;
    localparam logic [7:0] C_CONFIRM    = 8'hD0;
    localparam logic [7:0] C_ERASE      = 8'h20;
    localparam logic [7:0] C_PROG       = 8'h40;
    localparam logic [7:0] C_DWPROG     = 8'h30;
    localparam logic [7:0] C_LOCKSET    = 8'h60;
    localparam logic [7:0] C_LOCK       = 8'h01;
    localparam logic [7:0] C_LOCKDN     = 8'h2F;
    localparam logic [7:0] C_PROT       = 8'hC0;
endpackage

// File: rtl/fcd_seq.sv
// Command sequence tracker: decodes bus writes, follows multi-write
// sequences, gates codes by engine state and emits start/suspend/resume.
// Assumes: wr_en is a one-cycle strobe; engine busy/suspend are synchronous.
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              eng_busy,
    input  logic              eng_susp,
    output logic              op_start,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    output logic [ADDR_W-1:0] op_addr2,
    output logic [15:0]       op_data2,
    output logic              suspend_req,
    output logic              resume_req,
    output rd_mode_e          mode,
    output logic              set_erase_err,
    output logic              set_prog_err,
    output logic              clr_err
);
    localparam logic [ADDR_W-1:0] PAIR_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};

    seq_state_e        st_q, st_d;
    rd_mode_e          mode_d;
    op_kind_e          kind_d, last_q, last_d;
    logic              start_d, susp_d, res_d;
    logic [ADDR_W-1:0] addr_d, addr2_d;
    logic [15:0]       data_d, data2_d;
    logic [7:0]        cmd;
    logic              run, susp_erase;

    assign cmd        = wr_data[7:0];
    assign run        = eng_busy & ~eng_susp;
    assign susp_erase = eng_susp & (last_q == K_ERASE);

    // Next-state decode of one bus write against the current sequence state.
    always_comb begin
        st_d = st_q; mode_d = mode; kind_d = op_kind; last_d = last_q;
        start_d = 1'b0; susp_d = 1'b0; res_d = 1'b0;
        addr_d = op_addr; data_d = op_data; addr2_d = op_addr2; data2_d = op_data2;
        set_erase_err = 1'b0; set_prog_err = 1'b0; clr_err = 1'b0;
        if (wr_en) begin
            case (st_q)
                S_IDLE: begin
                    if (run) begin
                        if (cmd == C_READ_STAT) mode_d = M_STATUS;
                        else if (cmd == C_SUSPEND && last_q != K_PROT) begin
                            susp_d = 1'b1; mode_d = M_STATUS;
                        end
                    end else if (eng_susp) begin
                        case (cmd)
                            C_READ_ARRAY: mode_d = M_ARRAY;
                            C_READ_STAT:  mode_d = M_STATUS;
                            C_READ_SIG:   mode_d = M_SIG;
                            C_READ_QUERY: mode_d = M_QUERY;
                            C_CONFIRM: begin res_d = 1'b1; mode_d = M_STATUS; end
                            C_PROG:    if (susp_erase) begin st_d = S_PROG; mode_d = M_STATUS; end
                            C_LOCKSET: if (susp_erase) begin st_d = S_LOCK; mode_d = M_STATUS; end
                            C_PROT:    if (susp_erase) begin st_d = S_PROT; mode_d = M_STATUS; end
                            default: ;
                        endcase
                    end else begin
                        case (cmd)
                            C_READ_ARRAY: mode_d = M_ARRAY;
                            C_READ_STAT:  mode_d = M_STATUS;
                            C_READ_SIG:   mode_d = M_SIG;
                            C_READ_QUERY: mode_d = M_QUERY;
                            C_CLEAR:      clr_err = 1'b1;
                            C_ERASE:   begin st_d = S_ERASE; mode_d = M_STATUS; end
                            C_PROG:    begin st_d = S_PROG;  mode_d = M_STATUS; end
                            C_DWPROG:  begin st_d = S_DW1;   mode_d = M_STATUS; end
                            C_LOCKSET: begin st_d = S_LOCK;  mode_d = M_STATUS; end
                            C_PROT:    begin st_d = S_PROT;  mode_d = M_STATUS; end
                            default:   mode_d = M_ARRAY;
                        endcase
                    end
                end
                S_ERASE: begin
                    st_d = S_IDLE; mode_d = M_STATUS;
                    if (cmd == C_CONFIRM) begin
                        start_d = 1'b1; kind_d = K_ERASE; addr_d = wr_addr; data_d = wr_data;
                    end else begin
                        set_erase_err = 1'b1; set_prog_err = 1'b1;
                    end
                end
                S_PROG, S_PROT: begin
                    st_d = S_IDLE; mode_d = M_STATUS; start_d = 1'b1;
                    kind_d = (st_q == S_PROG) ? K_PROG : K_PROT;
                    addr_d = wr_addr; data_d = wr_data;
                end
                S_DW1: begin
                    st_d = S_DW2; addr_d = wr_addr; data_d = wr_data;
                end
                S_DW2: begin
                    st_d = S_IDLE;
                    if (((wr_addr ^ op_addr) & PAIR_MASK) == '0) begin
                        start_d = 1'b1; kind_d = K_DWPROG; mode_d = M_STATUS;
                        addr2_d = wr_addr; data2_d = wr_data;
                    end else begin
                        set_prog_err = 1'b1; mode_d = M_ARRAY;
                    end
                end
                S_LOCK: begin
                    st_d = S_IDLE; addr_d = wr_addr; data_d = wr_data;
                    case (cmd)
                        C_LOCK:    begin start_d = 1'b1; kind_d = K_LOCK;   end
                        C_CONFIRM: begin start_d = 1'b1; kind_d = K_UNLOCK; end
                        C_LOCKDN:  begin start_d = 1'b1; kind_d = K_LOCKDN; end
                        default:   mode_d = M_ARRAY;
                    endcase
                end
                default: begin st_d = S_IDLE; mode_d = M_ARRAY; end
            endcase
        end
        if (start_d && !eng_susp && kind_d inside {K_ERASE, K_PROG, K_DWPROG, K_PROT})
            last_d = kind_d;
    end

    // Sequence, mode and operation registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE; mode <= M_ARRAY; op_kind <= K_ERASE; last_q <= K_ERASE;
            op_start <= 1'b0; suspend_req <= 1'b0; resume_req <= 1'b0;
            op_addr <= '0; op_data <= '0; op_addr2 <= '0; op_data2 <= '0;
        end else begin
            st_q <= st_d; mode <= mode_d; op_kind <= kind_d; last_q <= last_d;
            op_start <= start_d; suspend_req <= susp_d; resume_req <= res_d;
            op_addr <= addr_d; op_data <= data_d; op_addr2 <= addr2_d; op_data2 <= data2_d;
        end
    end

    // R1: a reset edge leaves the decoder idle in array mode with no pulse.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (st_q == S_IDLE && mode == M_ARRAY && !op_start));
    // R7: a new command while the engine runs never starts an operation.
    a_r7_no_start_running: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && run && st_q == S_IDLE) |=> !op_start);
    // R3: a wrong erase confirm starts nothing.
    a_r3_bad_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q == S_ERASE && cmd != C_CONFIRM) |=> !op_start);
    // R9: a protection-register program is never suspended.
    a_r9_prot_no_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && run && last_q == K_PROT) |=> !suspend_req);
    // R8: resume only follows a write made while suspended.
    a_r8_resume_when_susp: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> $past(eng_susp));
endmodule

// File: rtl/fcd_status.sv
// Error flags of the status register (bit 5 erase, bit 4 program).
// Assumes: set and clear requests never coincide.
module fcd_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_erase_err,
    input  logic set_prog_err,
    input  logic clr_err,
    output logic err_erase,
    output logic err_prog
);
    // Sticky error flags, cleared only by the clear command or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_err) begin
            err_erase <= 1'b0;
            err_prog  <= 1'b0;
        end else begin
            if (set_erase_err) err_erase <= 1'b1;
            if (set_prog_err)  err_prog  <= 1'b1;
        end
    end

    // R10: clearing leaves both flags low.
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> (!err_erase && !err_prog));
    // R3: an erase-confirm error raises both flags together.
    a_r3_both_flags: assert property (@(posedge clk) disable iff (!rst_n)
        set_erase_err |=> (err_erase && err_prog));
endmodule

// File: rtl/fcd_readsel.sv
// Read-source selection and identifier word.
// Assumes: lock bits arrive for the block being read.
module fcd_readsel
    import fcd_pkg::*;
#(
    parameter logic [15:0] DEVICE_ID = 16'h5A3C,
    parameter logic [15:0] MAKER_ID  = 16'h0020
) (
    input  logic       clk,
    input  logic       rst_n,
    input  rd_mode_e   mode,
    input  logic       eng_busy,
    input  logic       eng_susp,
    input  logic [1:0] id_sel,
    input  logic       blk_locked,
    input  logic       blk_lockdown,
    output logic [1:0] rd_sel,
    output logic [15:0] id_word
);
    // Force status reads while an operation runs.
    always_comb rd_sel = (eng_busy && !eng_susp) ? M_STATUS : mode;

    // Identifier word by select index.
    always_comb begin
        case (id_sel)
            2'd0:    id_word = MAKER_ID;
            2'd1:    id_word = DEVICE_ID;
            2'd2:    id_word = {14'b0, blk_lockdown, blk_locked};
            default: id_word = 16'h0000;
        endcase
    end

    // R7: status is the read source whenever the engine runs.
    a_r7_status_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !eng_susp) |-> rd_sel == 2'd1);
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder: sequence tracker, error flags, read mux.
// Assumes: single clock domain; the engine drives busy/suspended synchronously.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int          ADDR_W    = 20,
    parameter logic [15:0] DEVICE_ID = 16'h5A3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              eng_busy,
    input  logic              eng_susp,
    input  logic [1:0]        id_sel,
    input  logic              blk_locked,
    input  logic              blk_lockdown,
    output logic              op_start,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    output logic [ADDR_W-1:0] op_addr2,
    output logic [15:0]       op_data2,
    output logic              suspend_req,
    output logic              resume_req,
    output logic [1:0]        rd_sel,
    output logic [15:0]       id_word,
    output logic              err_erase,
    output logic              err_prog
);
    op_kind_e kind;
    rd_mode_e mode;
    logic     set_e, set_p, clr;

    assign op_kind = kind;

    fcd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .eng_busy(eng_busy), .eng_susp(eng_susp),
        .op_start(op_start), .op_kind(kind), .op_addr(op_addr), .op_data(op_data),
        .op_addr2(op_addr2), .op_data2(op_data2),
        .suspend_req(suspend_req), .resume_req(resume_req), .mode(mode),
        .set_erase_err(set_e), .set_prog_err(set_p), .clr_err(clr)
    );

    fcd_status u_status (
        .clk(clk), .rst_n(rst_n), .set_erase_err(set_e), .set_prog_err(set_p),
        .clr_err(clr), .err_erase(err_erase), .err_prog(err_prog)
    );

    fcd_readsel #(.DEVICE_ID(DEVICE_ID)) u_rdsel (
        .clk(clk), .rst_n(rst_n), .mode(mode), .eng_busy(eng_busy), .eng_susp(eng_susp),
        .id_sel(id_sel), .blk_locked(blk_locked), .blk_lockdown(blk_lockdown),
        .rd_sel(rd_sel), .id_word(id_word)
    );
endmodule

// File: tb/flash_cmd_decoder_test.sv
// Directed bench for the flash command decoder.
module flash_cmd_decoder_test;
    localparam int AW = 20;
    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic eng_busy = 1'b0, eng_susp = 1'b0, blk_locked = 1'b0, blk_lockdown = 1'b0;
    logic [1:0] id_sel = 2'd0;
    logic op_start, suspend_req, resume_req, err_erase, err_prog;
    logic [2:0] op_kind;
    logic [AW-1:0] op_addr, op_addr2;
    logic [15:0] op_data, op_data2, id_word;
    logic [1:0] rd_sel;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .DEVICE_ID(16'h5A3C)) uut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    // One bus write; returns at the negedge after the capturing edge.
    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rd_sel", rd_sel, 0);
        chk("R1 errors", {err_erase, err_prog}, 0);
        chk("R1 pulses", {op_start, suspend_req, resume_req}, 0);
    endtask

    task automatic t_modes;
        wr(0, 16'h0070); chk("R10 status mode", rd_sel, 1);
        wr(0, 16'h0090); chk("R10 sig mode", rd_sel, 2);
        id_sel = 0; #1 chk("R11 maker", id_word, 16'h0020);
        id_sel = 1; #1 chk("R11 device", id_word, 16'h5A3C);
        blk_locked = 1; blk_lockdown = 0; id_sel = 2; #1 chk("R11 lock word", id_word, 16'h0001);
        blk_lockdown = 1; #1 chk("R11 lockdown word", id_word, 16'h0003);
        id_sel = 3; #1 chk("R11 spare word", id_word, 16'h0000);
        wr(0, 16'h0098); chk("R10 query mode", rd_sel, 3);
        wr(0, 16'h0012); chk("R10 undefined to array", rd_sel, 0);
        wr(0, 16'h0070); wr(0, 16'h00FF); chk("R10 array mode", rd_sel, 0);
    endtask

    task automatic t_erase;
        wr(20'h0AAAA, 16'h0020); chk("R2 no start on setup", op_start, 0);
        wr(20'h01234, 16'h00D0);
        chk("R2 start", op_start, 1); chk("R2 kind", op_kind, 0);
        chk("R2 addr", op_addr, 20'h01234); chk("R2 status read", rd_sel, 1);
        @(negedge clk); chk("R2 pulse one cycle", op_start, 0);
    endtask

    task automatic t_erase_bad;
        wr(0, 16'h0020); wr(20'h00100, 16'h0055);
        chk("R3 no start", op_start, 0);
        chk("R3 flags", {err_erase, err_prog}, 2'b11);
        chk("R3 status read", rd_sel, 1);
        wr(0, 16'h0050); chk("R10 clear", {err_erase, err_prog}, 0);
    endtask

    task automatic t_prog;
        wr(0, 16'h0040); wr(20'h00010, 16'hBEEF);
        chk("R4 prog start", op_start, 1); chk("R4 prog kind", op_kind, 1);
        chk("R4 prog addr/data", {op_addr, op_data}, {20'h00010, 16'hBEEF});
        wr(0, 16'h00C0); wr(20'h00081, 16'h1234);
        chk("R4 prot start", op_start, 1); chk("R4 prot kind", op_kind, 6);
        chk("R4 prot data", op_data, 16'h1234);
    endtask

    task automatic t_dw;
        wr(0, 16'h0030); wr(20'h00020, 16'hAAAA);
        chk("R5 no start after first word", op_start, 0);
        wr(20'h00021, 16'h5555);
        chk("R5 start", op_start, 1); chk("R5 kind", op_kind, 2);
        chk("R5 words", {op_addr, op_data, op_addr2, op_data2},
            {20'h00020, 16'hAAAA, 20'h00021, 16'h5555});
        wr(0, 16'h0030); wr(20'h00020, 16'h1111); wr(20'h00023, 16'h2222);
        chk("R5 mismatch no start", op_start, 0);
        chk("R5 mismatch flag", err_prog, 1);
        chk("R5 mismatch array", rd_sel, 0);
        wr(0, 16'h0050);
    endtask

    task automatic t_lock;
        wr(0, 16'h0060); wr(20'h00300, 16'h0001);
        chk("R6 lock", {op_start, op_kind}, {1'b1, 3'd3});
        chk("R6 lock addr", op_addr, 20'h00300);
        wr(0, 16'h0060); wr(20'h00300, 16'h00D0);
        chk("R6 unlock", {op_start, op_kind}, {1'b1, 3'd4});
        wr(0, 16'h0060); wr(20'h00300, 16'h002F);
        chk("R6 lockdown", {op_start, op_kind}, {1'b1, 3'd5});
        wr(0, 16'h0060); wr(20'h00300, 16'h0077);
        chk("R6 bad code", {op_start, rd_sel}, {1'b0, 2'd0});
    endtask

    task automatic t_busy_and_erase_suspend;
        wr(0, 16'h0020); wr(20'h04000, 16'h00D0);
        eng_busy = 1'b1;
        wr(0, 16'h0090); #1 chk("R7 status forced", rd_sel, 1);
        wr(0, 16'h0040); wr(0, 16'h1111);
        chk("R7 program ignored", op_start, 0);
        wr(0, 16'h00FF);
        wr(0, 16'h00B0); chk("R9 suspend pulse on erase", suspend_req, 1);
        eng_susp = 1'b1; #1
        chk("R7 ignored read modes", rd_sel, 1);
        wr(0, 16'h00FF); chk("R8 read array while suspended", rd_sel, 0);
        wr(0, 16'h0040); wr(20'h08000, 16'hC0DE);
        chk("R8 program in erase suspend", {op_start, op_kind}, {1'b1, 3'd1});
        wr(0, 16'h00D0); chk("R8 resume pulse", resume_req, 1);
        chk("R8 status after resume", rd_sel, 1);
        eng_susp = 1'b0; eng_busy = 1'b0;
    endtask

    task automatic t_prog_suspend;
        wr(0, 16'h0040); wr(20'h00050, 16'h0F0F);
        eng_busy = 1'b1;
        wr(0, 16'h00B0); chk("R9 suspend pulse on program", suspend_req, 1);
        eng_susp = 1'b1;
        wr(0, 16'h0040); wr(0, 16'h0098);
        chk("R8 program refused in program suspend", op_start, 0);
        chk("R8 query while suspended", rd_sel, 3);
        eng_susp = 1'b0; eng_busy = 1'b0;
        wr(0, 16'h00FF);
    endtask

    task automatic t_prot_nosusp;
        wr(0, 16'h00C0); wr(20'h00080, 16'h00FE);
        eng_busy = 1'b1;
        wr(0, 16'h00B0); chk("R9 protection not suspended", suspend_req, 0);
        eng_busy = 1'b0;
        wr(0, 16'h00FF);
    endtask

    task automatic t_reset_midseq;
        wr(0, 16'h0020);
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        wr(0, 16'h00D0);
        chk("R1 partial sequence dropped", op_start, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_erase();
        t_erase_bad();
        t_prog();
        t_dw();
        t_lock();
        t_busy_and_erase_suspend();
        t_prog_suspend();
        t_prot_nosusp();
        t_reset_midseq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule